// File: doc/BRIEF.md
# Open-Drain Channel Direction Arbiter

This block arbitrates direction on bidirectional open-drain channels. Each channel joins a host-side line and a card-side line, and both lines rest high through pull-ups. The block samples both lines. The first side seen pulled low becomes the leader for that transaction. The block then pulls the opposite side, the follower, low so that the level passes across. When the leader lets go, the follower is released and gets a short active pull-up pulse to recharge its line quickly. Arbitration opens again only after both lines have read high for a set number of consecutive samples. The default build has three identical channels (data and two auxiliary), and each has its own enable.

When a channel is disabled, the block releases the host side and holds the card line low. When the channel is enabled again, it first waits for both lines to settle high. Only then does it accept a new direction. All arbitration is synchronous to one clock. Line activity is expected to stay at or below 1 MHz, so a clock of a few tens of MHz gives many samples per bit.

Top module: `bidir_line_arbiter`

## Requirements
- R1: During and straight after synchronous reset, every channel has host_drv_lo=0, card_drv_lo=1, host_pu=0 and card_pu=0.
- R2: At the first clock edge that samples chan_en[i]=0, channel i goes to host_drv_lo=0, card_drv_lo=1 and both pull-up outputs 0. It stays there while disabled, whatever its inputs do.
- R3: In idle, a low on host_in[i] sets card_drv_lo[i]=1 at the second clock edge after the low is first present, and host_drv_lo[i] stays 0.
- R4: In idle, a low on card_in[i] sets host_drv_lo[i]=1 at the second clock edge after the low is first present, and card_drv_lo[i] stays 0.
- R5: If both inputs of an idle channel are first seen low at the same edge, the host side leads, which gives card_drv_lo=1 and host_drv_lo=0.
- R6: While a leader holds its line low, the follower drive stays on and the leader drive stays off, whatever the follower's external input does.
- R7: When the leader's input returns high, the follower drive drops at the second edge. From that same edge the follower-side pull-up output is 1 for exactly PU_CYCLES cycles, and the leader-side pull-up stays 0.
- R8: After a release, a new direction is taken only once both inputs have been sampled high for IDLE_HIGH consecutive cycles. A low seen earlier is ignored, and it restarts the count.
- R9: Channels are independent. Activity on one channel never changes the outputs of another.
- R10: When chan_en[i] rises, card_drv_lo[i] drops at the next edge. The channel then follows the R8 settle rule before it accepts a direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | NCH | Per-channel enable |
| host_in | input | NCH | Sampled level of each host-side line |
| card_in | input | NCH | Sampled level of each card-side line |
| host_drv_lo | output | NCH | Pull host-side line low |
| card_drv_lo | output | NCH | Pull card-side line low |
| host_pu | output | NCH | Active pull-up pulse on host-side line |
| card_pu | output | NCH | Active pull-up pulse on card-side line |

## Verification
If the lane state machine held a stale direction, a follower drive would stay on after the leader released. That shows on the drive output two edges after the release. A wrong settle counter would let a low be accepted too early, or never accepted, and a sweep of the drop point against the release shows this within IDLE_HIGH+2 edges. A wrong pull-up counter changes the pulse length, which shows on the pull-up output within PU_CYCLES+2 edges of the release.

// File: rtl/bla_pkg.sv
package bla_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_HOST_LEAD,
    ST_CARD_LEAD,
    ST_PU_CARD,
    ST_PU_HOST,
    ST_SETTLE
  } lane_state_t;
endpackage

// File: rtl/bla_sampler.sv
module bla_sampler #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] host_in,
  input  logic [NCH-1:0] card_in,
  output logic [NCH-1:0] host_s,
  output logic [NCH-1:0] card_s
);
  // One sampling register per line; lines rest high so reset to 1.
  for (genvar i = 0; i < NCH; i++) begin : g_smp
    always_ff @(posedge clk) begin
      if (rst) begin
        host_s[i] <= 1'b1;
        card_s[i] <= 1'b1;
      end else begin
        host_s[i] <= host_in[i];
        card_s[i] <= card_in[i];
      end
    end
  end
endmodule

// File: rtl/bla_lane.sv
module bla_lane
  import bla_pkg::*;
#(
  parameter int PU_CYCLES = 3,
  parameter int IDLE_HIGH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic host_s,
  input  logic card_s,
  output logic host_drv_lo,
  output logic card_drv_lo,
  output logic host_pu,
  output logic card_pu
);
  localparam int PW = (PU_CYCLES > 1) ? $clog2(PU_CYCLES) : 1;
  localparam int QW = $clog2(IDLE_HIGH + 1);
  localparam logic [PW-1:0] PU_LOAD = PW'(PU_CYCLES - 1);
  localparam logic [QW-1:0] Q_LAST  = QW'(IDLE_HIGH - 1);

  lane_state_t st, st_nx;
  logic [PW-1:0] pc, pc_nx;
  logic [QW-1:0] qc, qc_nx;
  logic both_hi;

  assign both_hi = host_s & card_s;

  always_comb begin
    st_nx = st;
    pc_nx = pc;
    qc_nx = qc;
    if (!en) begin
      st_nx = ST_OFF;
    end else begin
      case (st)
        ST_OFF: begin
          st_nx = ST_SETTLE;
          qc_nx = '0;
        end
        ST_IDLE: begin
          // host side is checked first: it wins a same-edge tie
          if (!host_s)      st_nx = ST_HOST_LEAD;
          else if (!card_s) st_nx = ST_CARD_LEAD;
        end
        ST_HOST_LEAD: begin
          if (host_s) begin
            st_nx = ST_PU_CARD;
            pc_nx = PU_LOAD;
          end
        end
        ST_CARD_LEAD: begin
          if (card_s) begin
            st_nx = ST_PU_HOST;
            pc_nx = PU_LOAD;
          end
        end
        ST_PU_CARD, ST_PU_HOST: begin
          if (pc == '0) begin
            st_nx = ST_SETTLE;
            qc_nx = '0;
          end else begin
            pc_nx = pc - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!both_hi)          qc_nx = '0;
          else if (qc == Q_LAST) st_nx = ST_IDLE;
          else                   qc_nx = qc + 1'b1;
        end
        default: st_nx = ST_OFF;
      endcase
    end
  end

  // Outputs registered from the next state so they move with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_OFF;
      pc          <= '0;
      qc          <= '0;
      host_drv_lo <= 1'b0;
      card_drv_lo <= 1'b1;
      host_pu     <= 1'b0;
      card_pu     <= 1'b0;
    end else begin
      st          <= st_nx;
      pc          <= pc_nx;
      qc          <= qc_nx;
      host_drv_lo <= (st_nx == ST_CARD_LEAD);
      card_drv_lo <= (st_nx == ST_HOST_LEAD) || (st_nx == ST_OFF);
      host_pu     <= (st_nx == ST_PU_HOST);
      card_pu     <= (st_nx == ST_PU_CARD);
    end
  end
endmodule

// File: rtl/bidir_line_arbiter.sv
module bidir_line_arbiter #(
  parameter int NCH       = 3,
  parameter int PU_CYCLES = 3,
  parameter int IDLE_HIGH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] host_in,
  input  logic [NCH-1:0] card_in,
  output logic [NCH-1:0] host_drv_lo,
  output logic [NCH-1:0] card_drv_lo,
  output logic [NCH-1:0] host_pu,
  output logic [NCH-1:0] card_pu
);
  logic [NCH-1:0] host_s, card_s;

  bla_sampler #(.NCH(NCH)) u_smp (
    .clk    (clk),
    .rst    (rst),
    .host_in(host_in),
    .card_in(card_in),
    .host_s (host_s),
    .card_s (card_s)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    bla_lane #(.PU_CYCLES(PU_CYCLES), .IDLE_HIGH(IDLE_HIGH)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .en         (chan_en[i]),
      .host_s     (host_s[i]),
      .card_s     (card_s[i]),
      .host_drv_lo(host_drv_lo[i]),
      .card_drv_lo(card_drv_lo[i]),
      .host_pu    (host_pu[i]),
      .card_pu    (card_pu[i])
    );
  end
endmodule

// File: rtl/bidir_line_arbiter_chk.sv
module bidir_line_arbiter_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] host_in,
  input logic [NCH-1:0] card_in,
  input logic [NCH-1:0] host_drv_lo,
  input logic [NCH-1:0] card_drv_lo,
  input logic [NCH-1:0] host_pu,
  input logic [NCH-1:0] card_pu
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
      !chan_en[i] |=> (card_drv_lo[i] && !host_drv_lo[i] && !host_pu[i] && !card_pu[i]));

    a_r5_one_direction: assert property (@(posedge clk) disable iff (rst)
      !(host_drv_lo[i] && card_drv_lo[i]));

    a_r3_card_follows_host: assert property (@(posedge clk) disable iff (rst)
      ($rose(card_drv_lo[i]) && $past(chan_en[i])) |-> !$past(host_in[i], 2));

    a_r4_host_follows_card: assert property (@(posedge clk) disable iff (rst)
      $rose(host_drv_lo[i]) |-> !$past(card_in[i], 2));

    a_r7_card_pu_after_drive: assert property (@(posedge clk) disable iff (rst)
      $rose(card_pu[i]) |-> ($past(card_drv_lo[i]) && !card_drv_lo[i]));

    a_r7_host_pu_after_drive: assert property (@(posedge clk) disable iff (rst)
      $rose(host_pu[i]) |-> ($past(host_drv_lo[i]) && !host_drv_lo[i]));

    a_r7_pu_one_side: assert property (@(posedge clk) disable iff (rst)
      !(host_pu[i] && card_pu[i]));
  end
endmodule

bind bidir_line_arbiter bidir_line_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chan_en    (chan_en),
  .host_in    (host_in),
  .card_in    (card_in),
  .host_drv_lo(host_drv_lo),
  .card_drv_lo(card_drv_lo),
  .host_pu    (host_pu),
  .card_pu    (card_pu)
);

// File: tb/bidir_line_arbiter_bench.sv
module bidir_line_arbiter_bench;
  localparam int NCH = 3;
  localparam int PU  = 3;
  localparam int IDH = 2;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] en, hx, cx;
  logic [NCH-1:0] host_in, card_in, host_drv_lo, card_drv_lo, host_pu, card_pu;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // wired-AND line model: external party and arbiter may both pull low
  assign host_in = hx & ~host_drv_lo;
  assign card_in = cx & ~card_drv_lo;

  bidir_line_arbiter #(.NCH(NCH), .PU_CYCLES(PU), .IDLE_HIGH(IDH)) u_bidir_line_arbiter (
    .clk(clk), .rst(rst), .chan_en(en), .host_in(host_in), .card_in(card_in),
    .host_drv_lo(host_drv_lo), .card_drv_lo(card_drv_lo),
    .host_pu(host_pu), .card_pu(card_pu)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int fol_drv(input int ch, input bit hs);
    return hs ? int'(card_drv_lo[ch]) : int'(host_drv_lo[ch]);
  endfunction
  function automatic int lead_drv(input int ch, input bit hs);
    return hs ? int'(host_drv_lo[ch]) : int'(card_drv_lo[ch]);
  endfunction
  function automatic int fol_pu(input int ch, input bit hs);
    return hs ? int'(card_pu[ch]) : int'(host_pu[ch]);
  endfunction
  function automatic int lead_pu(input int ch, input bit hs);
    return hs ? int'(host_pu[ch]) : int'(card_pu[ch]);
  endfunction

  task automatic set_lead(input int ch, input bit hs, input logic v);
    if (hs) hx[ch] = v; else cx[ch] = v;
  endtask
  task automatic set_fol(input int ch, input bit hs, input logic v);
    if (hs) cx[ch] = v; else hx[ch] = v;
  endtask

  task automatic others_quiet(input int ch);
    for (int o = 0; o < NCH; o++)
      if (o != ch) chk("R9", int'(host_drv_lo[o] | card_drv_lo[o] | host_pu[o] | card_pu[o]), 0);
  endtask

  // One transaction led by host side (hs=1, R3) or card side (hs=0, R4)
  task automatic txn(input int ch, input bit hs);
    string rq;
    rq = hs ? "R3" : "R4";
    set_lead(ch, hs, 1'b0);
    step(1);
    chk(rq, fol_drv(ch, hs), 0);
    step(1);
    chk(rq, fol_drv(ch, hs), 1);
    chk(rq, lead_drv(ch, hs), 0);
    others_quiet(ch);
    set_fol(ch, hs, 1'b0);
    for (int k = 0; k < 4; k++) begin
      if (k == 2) set_fol(ch, hs, 1'b1);
      step(1);
      chk("R6", fol_drv(ch, hs), 1);
      chk("R6", lead_drv(ch, hs), 0);
    end
    set_lead(ch, hs, 1'b1);
    step(1);
    chk("R7", fol_drv(ch, hs), 1);
    step(1);
    chk("R7", fol_drv(ch, hs), 0);
    chk("R7", fol_pu(ch, hs), 1);
    chk("R7", lead_pu(ch, hs), 0);
    for (int k = 1; k < PU; k++) begin
      step(1);
      chk("R7", fol_pu(ch, hs), 1);
    end
    step(1);
    chk("R7", fol_pu(ch, hs), 0);
  endtask

  // Sweep how long the lines stay high before a new host low appears
  task automatic gate_sweep(input int ch);
    txn(ch, 1'b1);
    hx[ch] = 1'b0;
    step(3);
    chk("R8", int'(card_drv_lo[ch]), 0);
    for (int d = 1; d <= 4; d++) begin
      hx[ch] = 1'b1;
      step(d);
      hx[ch] = 1'b0;
      step(2);
      chk("R8", int'(card_drv_lo[ch]), (d >= IDH) ? 1 : 0);
      if (d >= IDH) begin
        hx[ch] = 1'b1;
        step(PU + 2);
        hx[ch] = 1'b0;
      end
    end
    hx[ch] = 1'b1;
    step(IDH + 4);
  endtask

  initial begin
    rst = 1'b1;
    en  = '1;
    hx  = '1;
    cx  = '1;
    step(3);
    for (int c = 0; c < NCH; c++) begin
      chk("R1", int'(host_drv_lo[c]), 0);
      chk("R1", int'(card_drv_lo[c]), 1);
      chk("R1", int'(host_pu[c] | card_pu[c]), 0);
    end
    rst = 1'b0;
    step(IDH + 4);

    for (int c = 0; c < NCH; c++) begin
      txn(c, 1'b1);
      step(IDH + 3);
      txn(c, 1'b0);
      step(IDH + 3);
    end

    // R5: same-edge tie, host leads
    hx[1] = 1'b0;
    cx[1] = 1'b0;
    step(2);
    chk("R5", int'(card_drv_lo[1]), 1);
    chk("R5", int'(host_drv_lo[1]), 0);
    hx[1] = 1'b1;
    cx[1] = 1'b1;
    step(2);
    chk("R5", int'(card_drv_lo[1]), 0);
    step(PU + IDH + 3);

    gate_sweep(0);
    gate_sweep(2);

    // R2: disable in the middle of a card-led transaction
    cx[1] = 1'b0;
    step(2);
    chk("R4", int'(host_drv_lo[1]), 1);
    en[1] = 1'b0;
    step(1);
    chk("R2", int'(host_drv_lo[1]), 0);
    chk("R2", int'(card_drv_lo[1]), 1);
    cx[1] = 1'b1;
    hx[1] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R2", int'(host_drv_lo[1]), 0);
      chk("R2", int'(card_drv_lo[1]), 1);
      chk("R2", int'(host_pu[1] | card_pu[1]), 0);
    end
    others_quiet(1);
    hx[1] = 1'b1;
    step(1);

    // R10: enable releases card side, then settle rule applies
    en[1] = 1'b1;
    step(1);
    chk("R10", int'(card_drv_lo[1]), 0);
    chk("R10", int'(host_drv_lo[1]), 0);
    cx[1] = 1'b0;
    step(3);
    chk("R10", int'(host_drv_lo[1]), 0);
    cx[1] = 1'b1;
    step(IDH + 3);
    txn(1, 1'b0);
    step(IDH + 3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule